// File: doc/BRIEF.md
# Load-use pipeline interlock unit

This block is the hazard detector of a five-stage in-order pipeline (fetch, decode, execute, memory, write). Each cycle it looks at the descriptor of the instruction sitting in decode and at the loads that recently left decode. It raises a stall when an operand of the decode instruction depends on load data that cannot yet be delivered to the read port that needs it. It records every load that leaves decode as an age-ordered entry, so the number of stall cycles still owed is recomputed every cycle from what is in the pipe.

How long the wait lasts depends on two things. The first is the width of the load: byte data is ready one cycle later than word data. The second is the port that consumes the data. Ports A and B are fed by forwarding paths. Port C carries store data and the accumulate operand, and it has no forwarding path from loaded data. A block store reads its first transfer register on port C in its second execute cycle. If that register is still pending, the block holds the instruction in execute rather than in decode. While decode is stalled, fetch and decode hold and a bubble is sent into execute. A multi-cycle instruction that occupies execute also holds decode, and the cycles it spends there count toward the age of any older load.

The execute hold is a two-state machine. `S_RUN` is the normal state. The transition `S_RUN -> S_EXHOLD` happens when a block store leaves decode while its first transfer register is still owed data. `S_EXHOLD` asserts the execute stall and counts down. The transition `S_EXHOLD -> S_RUN` happens on the last owed cycle.

Top module: `ilk_unit`

## Requirements
- R1: After reset no load is recorded and all three outputs are low, even with a valid decode instruction that reads registers.
- R2: A word load followed at once by an instruction that reads the loaded register on port A or port B stalls that instruction in decode for 1 cycle. With one other instruction in between, there is no stall.
- R3: A byte load followed at once by a port A or port B reader of its result stalls that reader for 2 cycles. With one instruction in between, the stall is 1 cycle. A decode stall never lasts more than 2 consecutive cycles.
- R4: A port C reader (dec_cport=1, register on dec_rd_c) of a word load's result stalls 1 cycle when it follows at once and 0 cycles with one instruction in between. After a byte load, the same two spacings give 2 and 1 cycles.
- R5: Once a load has been out of decode for 3 or more cycles, it causes no stall. In particular, a multi-cycle instruction between a load and its consumer (ex_multi_busy high for one cycle after it issues) removes the interlock. While ex_multi_busy is high, stall_dec_o stays low.
- R6: For a block transfer (dec_blk=1, load or store), a base register still owed by a load stalls decode under the port A/B rules.
- R7: A block store (dec_blk=1, dec_blk_store=1) whose first transfer register comes from a byte load immediately before it leaves decode without a decode stall. It then asserts stall_ex_o for 1 cycle, starting in the next cycle. When the load is a word load, there is no execute stall.
- R8: Register index 15 never creates a dependency, whether as a source or as a load destination. Instructions that are not loads, and operand ports whose enable is low, create no dependency.
- R9: bubble_o is high exactly when stall_dec_o is high and stall_ex_o is low. A decode stall and an execute stall can be active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_rd_a | input | 4 | Source register read on port A |
| dec_en_a | input | 1 | Port A read is used |
| dec_rd_b | input | 4 | Source register read on port B |
| dec_en_b | input | 1 | Port B read is used |
| dec_rd_c | input | 4 | Source register read on port C |
| dec_cport | input | 1 | Store data or accumulate operand is read on port C |
| dec_blk | input | 1 | Instruction is a block transfer |
| dec_blk_store | input | 1 | Block transfer is a store |
| dec_base | input | 4 | Base register of the block transfer |
| dec_first | input | 4 | First register transferred by a block store |
| dec_load | input | 1 | Instruction is a single-register load |
| dec_ld_dst | input | 4 | Load destination register |
| dec_ld_byte | input | 1 | Load is byte wide (0 = word) |
| ex_multi_busy | input | 1 | Execute is held by a multi-cycle instruction this cycle |
| stall_dec_o | output | 1 | Hold fetch and decode because of a load dependency |
| stall_ex_o | output | 1 | Hold execute and everything behind it (block store second-cycle wait) |
| bubble_o | output | 1 | Insert a bubble into execute |

## Verification
The decode stall and the execute hold can be active in the same cycle. A byte load is followed by a block store that stores the loaded register first, and then by an instruction that reads the same register on port A. In the cycle after the store leaves decode, the execute hold is active and the reader still owes one cycle of data, so both stalls must be high and bubble_o must stay low, because execute is not moving. The bench checks the reader's stall count, the number of execute-hold cycles and the absence of any bubble for that sequence. It also compares every cycle of a random instruction stream against its own age-based model.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    localparam int ILK_REG_W = 4;

    typedef struct packed {
        logic                 vld;
        logic                 byte_w;
        logic [ILK_REG_W-1:0] dst;
    } ilk_ent_t;

    typedef enum logic {
        S_RUN    = 1'b0,
        S_EXHOLD = 1'b1
    } ilk_state_e;

endpackage

// File: rtl/ilk_load_track.sv
module ilk_load_track
    import ilk_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [ILK_REG_W-1:0]      push_dst,
    input  logic                      push_byte,
    output ilk_ent_t [DEPTH-1:0]      ents
);

    // Entry k holds the load that left decode k+1 cycles ago.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ents <= '0;
        end else begin
            ents[0].vld    <= push;
            ents[0].byte_w <= push & push_byte;
            ents[0].dst    <= push ? push_dst : '0;
            for (int k = 1; k < DEPTH; k++) begin
                ents[k] <= ents[k-1];
            end
        end
    end

endmodule

// File: rtl/ilk_need_calc.sv
module ilk_need_calc
    import ilk_pkg::*;
#(
    parameter int DEPTH  = 2,
    parameter int RDY_W  = 2,
    parameter int RDY_B  = 3,
    parameter int OFFS   = 0,
    parameter int CNT_W  = 2,
    parameter int PC_IDX = 15
) (
    input  logic                  en,
    input  logic [ILK_REG_W-1:0]  src,
    input  ilk_ent_t [DEPTH-1:0]  ents,
    output logic [CNT_W-1:0]      need
);

    // Cycles still owed = ready age - current age - offset; newest match wins.
    always_comb begin
        need = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (en && (src != ILK_REG_W'(PC_IDX)) && ents[k].vld && (ents[k].dst == src)) begin
                if (ents[k].byte_w) begin
                    need = (RDY_B > k + 1 + OFFS) ? CNT_W'(RDY_B - k - 1 - OFFS) : '0;
                end else begin
                    need = (RDY_W > k + 1 + OFFS) ? CNT_W'(RDY_W - k - 1 - OFFS) : '0;
                end
            end
        end
    end

endmodule

// File: rtl/ilk_unit.sv
module ilk_unit
    import ilk_pkg::*;
#(
    parameter int PC_IDX    = 15,
    parameter int RDY_AB_W  = 2,
    parameter int RDY_AB_B  = 3,
    parameter int RDY_C_W   = 2,
    parameter int RDY_C_B   = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dec_valid,
    input  logic [ILK_REG_W-1:0]  dec_rd_a,
    input  logic                  dec_en_a,
    input  logic [ILK_REG_W-1:0]  dec_rd_b,
    input  logic                  dec_en_b,
    input  logic [ILK_REG_W-1:0]  dec_rd_c,
    input  logic                  dec_cport,
    input  logic                  dec_blk,
    input  logic                  dec_blk_store,
    input  logic [ILK_REG_W-1:0]  dec_base,
    input  logic [ILK_REG_W-1:0]  dec_first,
    input  logic                  dec_load,
    input  logic [ILK_REG_W-1:0]  dec_ld_dst,
    input  logic                  dec_ld_byte,
    input  logic                  ex_multi_busy,
    output logic                  stall_dec_o,
    output logic                  stall_ex_o,
    output logic                  bubble_o
);

    localparam int MAX_AB  = (RDY_AB_W > RDY_AB_B) ? RDY_AB_W : RDY_AB_B;
    localparam int MAX_C   = (RDY_C_W > RDY_C_B) ? RDY_C_W : RDY_C_B;
    localparam int MAX_RDY = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
    localparam int DEPTH   = (MAX_RDY > 2) ? MAX_RDY - 1 : 1;
    localparam int CNT_W   = $clog2(MAX_RDY + 1);
    localparam int NUM_OPS = 4;   // A, B, block base, C

    ilk_ent_t [DEPTH-1:0]  ents;
    logic [ILK_REG_W-1:0]  op_src  [NUM_OPS];
    logic                  op_en   [NUM_OPS];
    logic [CNT_W-1:0]      op_need [NUM_OPS];
    logic [CNT_W-1:0]      need_dec;
    logic [CNT_W-1:0]      need_ex;
    logic                  issue;
    logic                  push;

    ilk_state_e            state, state_n;
    logic [CNT_W-1:0]      ex_cnt, ex_cnt_n;

    assign op_src[0] = dec_rd_a;  assign op_en[0] = dec_en_a;
    assign op_src[1] = dec_rd_b;  assign op_en[1] = dec_en_b;
    assign op_src[2] = dec_base;  assign op_en[2] = dec_blk;
    assign op_src[3] = dec_rd_c;  assign op_en[3] = dec_cport;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        if (g == NUM_OPS - 1) begin : g_cport
            ilk_need_calc #(
                .DEPTH(DEPTH), .RDY_W(RDY_C_W), .RDY_B(RDY_C_B),
                .OFFS(0), .CNT_W(CNT_W), .PC_IDX(PC_IDX)
            ) u_need (
                .en(op_en[g]), .src(op_src[g]), .ents(ents), .need(op_need[g])
            );
        end else begin : g_fwd
            ilk_need_calc #(
                .DEPTH(DEPTH), .RDY_W(RDY_AB_W), .RDY_B(RDY_AB_B),
                .OFFS(0), .CNT_W(CNT_W), .PC_IDX(PC_IDX)
            ) u_need (
                .en(op_en[g]), .src(op_src[g]), .ents(ents), .need(op_need[g])
            );
        end
    end

    // Block-store first register is read on port C one cycle after entering execute.
    ilk_need_calc #(
        .DEPTH(DEPTH), .RDY_W(RDY_C_W), .RDY_B(RDY_C_B),
        .OFFS(1), .CNT_W(CNT_W), .PC_IDX(PC_IDX)
    ) u_need_ex (
        .en(dec_blk & dec_blk_store), .src(dec_first), .ents(ents), .need(need_ex)
    );

    always_comb begin
        need_dec = '0;
        for (int i = 0; i < NUM_OPS; i++) begin
            if (op_need[i] > need_dec) need_dec = op_need[i];
        end
    end

    assign issue = dec_valid & ~stall_dec_o & ~stall_ex_o & ~ex_multi_busy;
    assign push  = issue & dec_load & (dec_ld_dst != ILK_REG_W'(PC_IDX));

    ilk_load_track #(.DEPTH(DEPTH)) u_track (
        .clk(clk), .rst_n(rst_n), .push(push),
        .push_dst(dec_ld_dst), .push_byte(dec_ld_byte), .ents(ents)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_RUN;
            ex_cnt <= '0;
        end else begin
            state  <= state_n;
            ex_cnt <= ex_cnt_n;
        end
    end

    // Next state
    always_comb begin
        state_n  = state;
        ex_cnt_n = ex_cnt;
        unique case (state)
            S_RUN: begin
                if (issue && (need_ex != '0)) begin
                    state_n  = S_EXHOLD;
                    ex_cnt_n = need_ex;
                end
            end
            S_EXHOLD: begin
                ex_cnt_n = ex_cnt - 1'b1;
                if (ex_cnt <= CNT_W'(1)) begin
                    state_n  = S_RUN;
                    ex_cnt_n = '0;
                end
            end
            default: begin
                state_n  = S_RUN;
                ex_cnt_n = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        stall_ex_o  = (state == S_EXHOLD);
        stall_dec_o = dec_valid & ~ex_multi_busy & (need_dec != '0);
        bubble_o    = stall_dec_o & ~stall_ex_o;
    end

    AST_PC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_en_a && dec_rd_a == ILK_REG_W'(PC_IDX) && !dec_en_b && !dec_cport && !dec_blk)
        |-> !stall_dec_o) else $error("AST_PC_FREE"); // R8

    AST_EX_FROM_BLKST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_ex_o) |-> $past(dec_valid && dec_blk && dec_blk_store && !stall_dec_o))
        else $error("AST_EX_FROM_BLKST"); // R7

    AST_DEC_STALL_MAX2: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_dec_o && $past(stall_dec_o)) |=> !stall_dec_o)
        else $error("AST_DEC_STALL_MAX2"); // R3

    AST_GAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(issue) && !$past(issue, 2)) |-> !stall_dec_o)
        else $error("AST_GAP_CLEARS"); // R5

endmodule

// File: tb/ilk_unit_tb_top.sv
module ilk_unit_tb_top;

    typedef struct {
        logic [3:0] a, b, c, base, first, dst;
        logic ena, enb, cport, blk, blkst, ld, byt, multi;
    } desc_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_valid = 1'b0;
    logic [3:0] dec_rd_a = '0, dec_rd_b = '0, dec_rd_c = '0, dec_base = '0, dec_first = '0, dec_ld_dst = '0;
    logic dec_en_a = 0, dec_en_b = 0, dec_cport = 0, dec_blk = 0, dec_blk_store = 0;
    logic dec_load = 0, dec_ld_byte = 0, ex_multi_busy = 0;
    logic stall_dec_o, stall_ex_o, bubble_o;

    int n_checks = 0, n_fail = 0, cyc = 0;
    int ex_seen = 0, bub_seen = 0;
    bit chk_on = 0;

    // bench model state
    bit         hv [2];
    logic [3:0] hd [2];
    bit         hb [2];
    int         m_excnt = 0, m_exneed = 0;
    bit         m_iss = 0;

    always #5 clk = ~clk;

    ilk_unit dut_i (
        .clk, .rst_n, .dec_valid, .dec_rd_a, .dec_en_a, .dec_rd_b, .dec_en_b,
        .dec_rd_c, .dec_cport, .dec_blk, .dec_blk_store, .dec_base, .dec_first,
        .dec_load, .dec_ld_dst, .dec_ld_byte, .ex_multi_busy,
        .stall_dec_o, .stall_ex_o, .bubble_o
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Owed cycles per requirement rules: ready age 2 for word, 3 for byte.
    function automatic int mneed(bit en, logic [3:0] s, int offs);
        int n = 0;
        for (int age = 2; age >= 1; age--) begin
            if (en && s != 4'd15 && hv[age-1] && hd[age-1] == s) begin
                n = (hb[age-1] ? 3 : 2) - age - offs;
                if (n < 0) n = 0;
            end
        end
        return n;
    endfunction

    always @(negedge clk) begin
        int nd;
        bit e_dec, e_ex, e_bub;
        if (chk_on) begin
            nd = mneed(dec_en_a, dec_rd_a, 0);
            if (mneed(dec_en_b, dec_rd_b, 0) > nd) nd = mneed(dec_en_b, dec_rd_b, 0);
            if (mneed(dec_blk, dec_base, 0) > nd) nd = mneed(dec_blk, dec_base, 0);
            if (mneed(dec_cport, dec_rd_c, 0) > nd) nd = mneed(dec_cport, dec_rd_c, 0);
            e_dec = dec_valid && !ex_multi_busy && nd > 0;
            e_ex  = m_excnt > 0;
            e_bub = e_dec && !e_ex;
            m_iss = dec_valid && !e_dec && !e_ex && !ex_multi_busy;
            m_exneed = mneed(dec_blk && dec_blk_store, dec_first, 1);
            check("R9 model {dec,ex,bubble}", {stall_dec_o, stall_ex_o, bubble_o}, {e_dec, e_ex, e_bub});
            if (stall_ex_o) ex_seen++;
            if (bubble_o) bub_seen++;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            hv[0] <= 0; hv[1] <= 0; m_excnt <= 0;
        end else begin
            hv[1] <= hv[0]; hd[1] <= hd[0]; hb[1] <= hb[0];
            hv[0] <= m_iss && dec_load && dec_ld_dst != 4'd15;
            hd[0] <= dec_ld_dst; hb[0] <= dec_ld_byte;
            if (m_excnt > 0) m_excnt <= m_excnt - 1;
            else if (m_iss && m_exneed > 0) m_excnt <= m_exneed;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    function automatic desc_t d_nop();
        desc_t d;
        d.a = 0; d.b = 0; d.c = 0; d.base = 0; d.first = 0; d.dst = 0;
        d.ena = 0; d.enb = 0; d.cport = 0; d.blk = 0; d.blkst = 0; d.ld = 0; d.byt = 0; d.multi = 0;
        return d;
    endfunction
    function automatic desc_t d_ld(logic [3:0] r, bit byt);
        desc_t d = d_nop(); d.ld = 1; d.dst = r; d.byt = byt; return d;
    endfunction
    function automatic desc_t d_a(logic [3:0] r);
        desc_t d = d_nop(); d.ena = 1; d.a = r; return d;
    endfunction
    function automatic desc_t d_b(logic [3:0] r);
        desc_t d = d_nop(); d.enb = 1; d.b = r; return d;
    endfunction
    function automatic desc_t d_c(logic [3:0] r);
        desc_t d = d_nop(); d.cport = 1; d.c = r; return d;
    endfunction
    function automatic desc_t d_blk(logic [3:0] base, bit st, logic [3:0] first);
        desc_t d = d_nop(); d.blk = 1; d.base = base; d.blkst = st; d.first = first; return d;
    endfunction

    // Present one instruction, wait until it leaves decode; returns decode stall cycles.
    task automatic run(input desc_t d, output int nd);
        bit done;
        dec_valid = 1;
        dec_rd_a = d.a; dec_en_a = d.ena; dec_rd_b = d.b; dec_en_b = d.enb;
        dec_rd_c = d.c; dec_cport = d.cport; dec_blk = d.blk; dec_blk_store = d.blkst;
        dec_base = d.base; dec_first = d.first; dec_load = d.ld; dec_ld_dst = d.dst; dec_ld_byte = d.byt;
        nd = 0;
        forever begin
            @(negedge clk);
            if (stall_dec_o) nd++;
            done = dec_valid && !stall_dec_o && !stall_ex_o && !ex_multi_busy;
            @(posedge clk); #1;
            ex_multi_busy = 0;
            if (done) break;
        end
        ex_multi_busy = d.multi;
    endtask

    task automatic run0(input desc_t d);
        int nd;
        run(d, nd);
    endtask

    task automatic flush();
        for (int i = 0; i < 3; i++) run0(d_nop());
    endtask

    initial begin
        int nd, e0, b0;
        desc_t d;
        void'($urandom(32'hC0FFEE));
        dec_valid = 1; dec_en_a = 1; dec_rd_a = 4'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset outputs", {stall_dec_o, stall_ex_o, bubble_o}, 0);
        #1 rst_n = 1;
        @(negedge clk);
        check("R1 after reset no stall", {stall_dec_o, stall_ex_o, bubble_o}, 0);
        @(posedge clk); #1;
        chk_on = 1;
        dec_valid = 0;

        // R2
        run0(d_ld(1, 0)); run(d_a(1), nd); check("R2 word A d1", nd, 1); flush();
        run0(d_ld(1, 0)); run0(d_nop()); run(d_a(1), nd); check("R2 word A d2", nd, 0); flush();
        run0(d_ld(2, 0)); run(d_b(2), nd); check("R2 word B d1", nd, 1); flush();
        // R3
        run0(d_ld(1, 1)); run(d_a(1), nd); check("R3 byte A d1", nd, 2); flush();
        run0(d_ld(1, 1)); run0(d_nop()); run(d_b(1), nd); check("R3 byte B d2", nd, 1); flush();
        // R4
        run0(d_ld(3, 0)); run(d_c(3), nd); check("R4 word C d1", nd, 1); flush();
        run0(d_ld(3, 0)); run0(d_nop()); run(d_c(3), nd); check("R4 word C d2", nd, 0); flush();
        run0(d_ld(3, 1)); run(d_c(3), nd); check("R4 byte C d1", nd, 2); flush();
        run0(d_ld(3, 1)); run0(d_nop()); run(d_c(3), nd); check("R4 byte C d2", nd, 1); flush();
        // R5
        d = d_nop(); d.multi = 1;
        run0(d_ld(1, 1)); run0(d); run(d_a(1), nd); check("R5 multi between", nd, 0); flush();
        // R6
        run0(d_ld(4, 0)); run(d_blk(4, 0, 0), nd); check("R6 blk base word", nd, 1); flush();
        run0(d_ld(4, 1)); run(d_blk(4, 1, 0), nd); check("R6 blk base byte", nd, 2); flush();
        // R7
        e0 = ex_seen;
        run0(d_ld(2, 1)); run(d_blk(5, 1, 2), nd); check("R7 blk store no dec stall", nd, 0);
        run0(d_nop()); check("R7 byte first reg ex stall", ex_seen - e0, 1); flush();
        e0 = ex_seen;
        run0(d_ld(2, 0)); run0(d_blk(5, 1, 2)); run0(d_nop());
        check("R7 word first reg no ex stall", ex_seen - e0, 0); flush();
        // R8
        run0(d_ld(15, 1)); run(d_a(15), nd); check("R8 pc dest/src", nd, 0); flush();
        run0(d_ld(1, 1)); run(d_a(15), nd); check("R8 pc src", nd, 0); flush();
        d = d_nop(); d.dst = 1; d.byt = 1;
        run0(d); run(d_a(1), nd); check("R8 non-load", nd, 0); flush();
        d = d_a(1); d.ena = 0;
        run0(d_ld(1, 1)); run(d, nd); check("R8 port disabled", nd, 0); flush();
        // R9
        b0 = bub_seen;
        run0(d_ld(1, 1)); run0(d_a(1)); check("R9 bubble per stall", bub_seen - b0, 2); flush();
        e0 = ex_seen; b0 = bub_seen;
        run0(d_ld(3, 1)); run0(d_blk(6, 1, 3)); run(d_a(3), nd);
        check("R9 coexist dec stall", nd, 1);
        check("R9 coexist ex stall", ex_seen - e0, 1);
        check("R9 coexist no bubble", bub_seen - b0, 0);
        flush();

        // constrained random stream
        for (int i = 0; i < 400; i++) begin
            d = d_nop();
            d.a = (($urandom % 5) < 4) ? 4'($urandom % 4) : 4'd15;
            d.b = 4'($urandom % 4); d.c = 4'($urandom % 4);
            d.base = 4'($urandom % 4); d.first = 4'($urandom % 4);
            d.dst = (($urandom % 6) < 5) ? 4'($urandom % 4) : 4'd15;
            d.ena = ($urandom % 2) == 0; d.enb = ($urandom % 3) == 0;
            d.cport = ($urandom % 4) == 0; d.blk = ($urandom % 5) == 0;
            d.blkst = ($urandom % 2) == 0; d.ld = ($urandom % 3) == 0;
            d.byt = ($urandom % 2) == 0; d.multi = ($urandom % 7) == 0;
            run0(d);
        end
        flush();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule